// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block holds the power-management control bits of a small 8-bit microcontroller and sequences the Idle and Stop low-power modes around them. Software sets an Idle request to halt the CPU until an interrupt arrives. It sets a Stop request to also gate off the oscillator domain. The block also holds a power-fail interrupt enable. The Stop request is protected: it is accepted only inside a short write window. Software opens that window by writing two key bytes to a separate unlock port.

The block drives a CPU halt signal, an enable for the oscillator clock domain, a run enable for the watchdog timer, and the ALE and PSEN pad levels. Stop can be left only by a reset. When a power-on reset, or an external reset that ends Stop, is released, the block holds the CPU halted for a fixed oscillator-stabilisation interval. That interval is counted on the free-running clock.

Top module: `pwr_mode_top`

## Requirements
- R1: While `porRst` or `extRst` is high, `cpuHalt` is 1. Any reset edge clears the whole register, so `regRdData` reads 0x00.
- R2: Bit 3 of the register is the power-fail interrupt enable. It is written by any register write accepted while the CPU is running, it reads back on `regRdData[3]`, and it drives `pfIntEn`.
- R3: Writing 1 to bit 0 (Idle) sets `cpuHalt`=1, `alePin`=1 and `psenPin`=1. While `cpuHalt` is 1, register writes are ignored.
- R4: An `intPulse` clears the Idle bit on the next clock edge, and `cpuHalt` then drops.
- R5: A register write with bit 1 (Stop) set leaves the Stop bit at 0 when no unlock window is open.
- R6: An unlock window opens when the unlock port receives 0xAA and then 0x55 as consecutive unlock writes. The window covers the TA_WINDOW (default 4) clock edges after the 0x55 edge. A write with bit 1 set on any of those edges, including the last one, sets Stop.
- R7: A Stop write on clock edge TA_WINDOW+1 after the 0x55 edge is ignored.
- R8: When a single accepted write sets both bit 1 and bit 0, Stop is set and Idle reads 0.
- R9: While Stop is set: `oscClkEn`=0, `wdtRunEn`=0, `cpuHalt`=1, `alePin`=1 and `psenPin`=0. Neither `intPulse` nor a register write changes the register.
- R10: Stop clears only on a reset. After an external reset that ends Stop is released, `cpuHalt` stays 1 up to the STAB_CYCLES-th (default 21504) clock edge, counting the first edge at which the reset is sampled low as edge 1. `cpuHalt` falls just after that edge.
- R11: An external reset given while Stop is not set adds no stabilisation hold: `cpuHalt` is 0 as soon as the reset is released. A power-on reset is always followed by the STAB_CYCLES hold.
- R12: While neither Idle nor Stop is set, `alePin` follows `cpuAle` and `psenPin` follows `cpuPsen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| porRst | input | 1 | Power-on reset, active high, synchronous |
| extRst | input | 1 | External reset pin, active high, synchronous |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| taWrEn | input | 1 | Unlock port write strobe |
| taWrData | input | 8 | Unlock port write data (keys 0xAA then 0x55) |
| intPulse | input | 1 | Interrupt event, one clock wide |
| cpuAle | input | 1 | ALE level the CPU drives in normal run |
| cpuPsen | input | 1 | PSEN level the CPU drives in normal run |
| regRdData | output | 8 | Register read: bit 3 power-fail enable, bit 1 Stop, bit 0 Idle |
| pfIntEn | output | 1 | Power-fail interrupt enable |
| cpuHalt | output | 1 | CPU halted (reset, stabilisation, Idle or Stop) |
| oscClkEn | output | 1 | Clock enable for the oscillator domain |
| wdtRunEn | output | 1 | Watchdog run enable |
| alePin | output | 1 | ALE pad level |
| psenPin | output | 1 | PSEN pad level |

## Verification
Stop requests are tried in three forms: with no unlock sequence, one edge after the window has expired, and on the last edge of an open window. Comparing them separates a correct window length from one that is off by a cycle. The both-bits write shows whether Stop wins over Idle. Interrupts and writes are applied both in Idle and in Stop, which shows that only Idle reacts to them. External resets are applied both from run and from Stop, and the release edge of `cpuHalt` is located exactly. This separates the stabilisation hold from a plain reset and catches a counter that ends one cycle early or late.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  // strobes from control to the register datapath
  typedef struct packed {
    logic clrAll;   // any reset edge
    logic wrPlain;  // accepted write of unprotected bits
    logic wrStop;   // accepted write that may touch the Stop bit
    logic clrIdle;  // interrupt wake
  } pmStrobe_t;

  typedef struct packed {
    logic stop;
    logic idle;
  } pmStatus_t;

  localparam int unsigned BIT_IDLE = 0;
  localparam int unsigned BIT_STOP = 1;
  localparam int unsigned BIT_PFIE = 3;
  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
endpackage

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs
  import pwr_mode_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  pmStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  output pmStatus_t         status,
  output logic              pfieQ,
  output logic [DATA_W-1:0] rdData
);
  logic idleQ, stopQ, pfieR;

  always_ff @(posedge clk) begin
    if (stb.clrAll) begin
      idleQ <= 1'b0;
      stopQ <= 1'b0;
      pfieR <= 1'b0;
    end else if (stb.wrStop && wrData[BIT_STOP]) begin
      // Stop wins over a simultaneous Idle request
      stopQ <= 1'b1;
      idleQ <= 1'b0;
      pfieR <= wrData[BIT_PFIE];
    end else begin
      if (stb.wrPlain) begin
        idleQ <= wrData[BIT_IDLE];
        pfieR <= wrData[BIT_PFIE];
      end
      if (stb.clrIdle) idleQ <= 1'b0;
    end
  end

  always_comb begin
    rdData           = '0;
    rdData[BIT_IDLE] = idleQ;
    rdData[BIT_STOP] = stopQ;
    rdData[BIT_PFIE] = pfieR;
  end

  assign status = '{stop: stopQ, idle: idleQ};
  assign pfieQ  = pfieR;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 21504,
  parameter int unsigned TA_WINDOW   = 4
) (
  input  logic       clk,
  input  logic       porRst,
  input  logic       extRst,
  input  logic       regWrEn,
  input  logic       taWrEn,
  input  logic [7:0] taWrData,
  input  logic       intPulse,
  input  pmStatus_t  status,
  output pmStrobe_t  stb,
  output logic       waking,
  output logic       cpuHalt
);
  localparam int unsigned CNT_W = $clog2(STAB_CYCLES + 1);
  localparam int unsigned TA_W  = $clog2(TA_WINDOW + 1);

  typedef enum logic {KEY_WAIT, KEY_ARMED} keyState_t;

  keyState_t      keyState;
  logic [TA_W-1:0]  winCnt;
  logic [CNT_W-1:0] stabCnt;
  logic             wakingQ;
  logic             anyRst, winOpen, keyDone;

  assign anyRst  = porRst | extRst;
  assign winOpen = (winCnt != '0);
  assign keyDone = taWrEn && (keyState == KEY_ARMED) && (taWrData == KEY_SECOND);
  assign cpuHalt = anyRst | wakingQ | status.stop | status.idle;
  assign waking  = wakingQ;

  always_comb begin
    stb.clrAll  = anyRst;
    stb.wrPlain = regWrEn & ~cpuHalt;
    stb.wrStop  = regWrEn & ~cpuHalt & winOpen;
    stb.clrIdle = intPulse;
  end

  // stabilisation hold and unlock window
  always_ff @(posedge clk) begin
    if (porRst) begin
      wakingQ  <= 1'b1;
      stabCnt  <= '0;
      keyState <= KEY_WAIT;
      winCnt   <= '0;
    end else if (extRst) begin
      if (status.stop || wakingQ) wakingQ <= 1'b1;
      stabCnt  <= '0;
      keyState <= KEY_WAIT;
      winCnt   <= '0;
    end else begin
      if (wakingQ) begin
        if (stabCnt == CNT_W'(STAB_CYCLES - 1)) wakingQ <= 1'b0;
        else stabCnt <= stabCnt + 1'b1;
      end
      if (taWrEn) begin
        if (taWrData == KEY_FIRST && !keyDone) keyState <= KEY_ARMED;
        else keyState <= KEY_WAIT;
      end
      if (keyDone) winCnt <= TA_W'(TA_WINDOW);
      else if (winOpen) winCnt <= winCnt - 1'b1;
    end
  end
endmodule

// File: rtl/pwr_mode_top.sv
module pwr_mode_top
  import pwr_mode_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 21504,
  parameter int unsigned TA_WINDOW   = 4
) (
  input  logic       clk,
  input  logic       porRst,
  input  logic       extRst,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       taWrEn,
  input  logic [7:0] taWrData,
  input  logic       intPulse,
  input  logic       cpuAle,
  input  logic       cpuPsen,
  output logic [7:0] regRdData,
  output logic       pfIntEn,
  output logic       cpuHalt,
  output logic       oscClkEn,
  output logic       wdtRunEn,
  output logic       alePin,
  output logic       psenPin
);
  pmStrobe_t stb;
  pmStatus_t status;
  logic      waking;

  pwr_mode_ctrl #(.STAB_CYCLES(STAB_CYCLES), .TA_WINDOW(TA_WINDOW)) u_ctrl (
    .clk(clk), .porRst(porRst), .extRst(extRst), .regWrEn(regWrEn),
    .taWrEn(taWrEn), .taWrData(taWrData), .intPulse(intPulse),
    .status(status), .stb(stb), .waking(waking), .cpuHalt(cpuHalt)
  );

  pwr_mode_regs #(.DATA_W(8)) u_regs (
    .clk(clk), .stb(stb), .wrData(regWrData), .status(status),
    .pfieQ(pfIntEn), .rdData(regRdData)
  );

  assign oscClkEn = ~status.stop;
  assign wdtRunEn = ~status.stop & ~waking;
  assign alePin   = (status.stop | status.idle) ? 1'b1 : cpuAle;
  assign psenPin  = status.stop ? 1'b0 : (status.idle ? 1'b1 : cpuPsen);
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk (
  input logic       clk,
  input logic       porRst,
  input logic       extRst,
  input logic       regWrEn,
  input logic       intPulse,
  input logic       wrStopQ,
  input logic [7:0] regRdData,
  input logic       cpuHalt,
  input logic       oscClkEn,
  input logic       wdtRunEn,
  input logic       alePin,
  input logic       psenPin
);
  a_r9_stop_outputs: assert property (@(posedge clk) disable iff (porRst)
    regRdData[1] |-> (!oscClkEn && !wdtRunEn && cpuHalt && alePin && !psenPin));

  a_r3_idle_pins: assert property (@(posedge clk) disable iff (porRst)
    (regRdData[0] && !regRdData[1]) |-> (alePin && psenPin && cpuHalt));

  a_r4_int_clears_idle: assert property (@(posedge clk) disable iff (porRst || extRst)
    (intPulse && regRdData[0]) |=> !regRdData[0]);

  a_r5_stop_needs_window: assert property (@(posedge clk) disable iff (porRst)
    $rose(regRdData[1]) |-> $past(regWrEn && wrStopQ));

  a_r10_stop_leaves_on_reset: assert property (@(posedge clk) disable iff (porRst)
    $fell(regRdData[1]) |-> $past(extRst));
endmodule

bind pwr_mode_top pwr_mode_chk u_chk (
  .clk(clk), .porRst(porRst), .extRst(extRst), .regWrEn(regWrEn),
  .intPulse(intPulse), .wrStopQ(stb.wrStop), .regRdData(regRdData),
  .cpuHalt(cpuHalt), .oscClkEn(oscClkEn), .wdtRunEn(wdtRunEn),
  .alePin(alePin), .psenPin(psenPin)
);

// File: tb/pwr_mode_top_test.sv
module pwr_mode_top_test;
  localparam int STAB = 21504;
  localparam int WIN  = 4;

  logic       clk = 1'b0;
  logic       porRst = 1'b1, extRst = 1'b0;
  logic       regWrEn = 1'b0, taWrEn = 1'b0, intPulse = 1'b0;
  logic [7:0] regWrData = '0, taWrData = '0;
  logic       cpuAle = 1'b0, cpuPsen = 1'b0;
  logic [7:0] regRdData;
  logic       pfIntEn, cpuHalt, oscClkEn, wdtRunEn, alePin, psenPin;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_mode_top #(.STAB_CYCLES(STAB), .TA_WINDOW(WIN)) uut (
    .clk(clk), .porRst(porRst), .extRst(extRst), .regWrEn(regWrEn),
    .regWrData(regWrData), .taWrEn(taWrEn), .taWrData(taWrData),
    .intPulse(intPulse), .cpuAle(cpuAle), .cpuPsen(cpuPsen),
    .regRdData(regRdData), .pfIntEn(pfIntEn), .cpuHalt(cpuHalt),
    .oscClkEn(oscClkEn), .wdtRunEn(wdtRunEn), .alePin(alePin), .psenPin(psenPin)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic unlock();
    taWrEn = 1'b1; taWrData = 8'hAA;
    step();
    taWrData = 8'h55;
    step();
    taWrEn = 1'b0;
  endtask

  // called at the negedge where reset has just been dropped
  task automatic measureRelease(input string req, input int expEdge);
    int firstDrop = -1;
    for (int k = 1; k <= STAB + 2; k++) begin
      step();
      if (firstDrop < 0 && cpuHalt == 1'b0) firstDrop = k;
    end
    chk(req, firstDrop, expEdge);
  endtask

  task automatic t_por();
    step(3);
    chk("R1 por read", regRdData, 8'h00);
    chk("R1 por halt", cpuHalt, 1);
    porRst = 1'b0;
    measureRelease("R11 por hold edge", STAB);
  endtask

  task automatic t_pfie();
    regWrite(8'h08);
    chk("R2 pfie read", regRdData, 8'h08);
    chk("R2 pfie out", pfIntEn, 1);
    regWrite(8'h00);
    chk("R2 pfie clear", pfIntEn, 0);
  endtask

  task automatic t_runPins();
    cpuAle = 1'b0; cpuPsen = 1'b1; step();
    chk("R12 ale pass", alePin, 0);
    chk("R12 psen pass", psenPin, 1);
    cpuAle = 1'b1; cpuPsen = 1'b0; step();
    chk("R12 ale pass2", {alePin, psenPin}, 2'b10);
  endtask

  task automatic t_stopLocked();
    regWrite(8'h02);
    chk("R5 no unlock", regRdData, 8'h00);
    chk("R5 no halt", cpuHalt, 0);
    unlock();
    step(WIN);
    regWrite(8'h02);
    chk("R7 expired window", regRdData, 8'h00);
    chk("R7 osc still on", oscClkEn, 1);
  endtask

  task automatic t_idle();
    cpuAle = 1'b0; cpuPsen = 1'b0;
    regWrite(8'h01);
    chk("R3 idle set", regRdData, 8'h01);
    chk("R3 idle halt", cpuHalt, 1);
    chk("R3 idle pins", {alePin, psenPin}, 2'b11);
    regWrite(8'h08);
    chk("R3 write ignored", regRdData, 8'h01);
    intPulse = 1'b1; step(); intPulse = 1'b0;
    chk("R4 int clears", regRdData, 8'h00);
    chk("R4 resume", cpuHalt, 0);
  endtask

  task automatic t_extRun();
    regWrite(8'h08);
    extRst = 1'b1; step();
    chk("R1 ext halt", cpuHalt, 1);
    step();
    chk("R1 ext read", regRdData, 8'h00);
    extRst = 1'b0;
    #1;
    chk("R11 no hold", cpuHalt, 0);
    step();
    chk("R11 no hold next", cpuHalt, 0);
  endtask

  task automatic t_stopEnter();
    cpuAle = 1'b0; cpuPsen = 1'b1;
    unlock();
    step(WIN - 1);
    regWrite(8'h03);
    chk("R6 stop last edge", regRdData[1], 1);
    chk("R8 idle dropped", regRdData, 8'h02);
    chk("R9 osc off", oscClkEn, 0);
    chk("R9 wdt off", wdtRunEn, 0);
    chk("R9 pins", {cpuHalt, alePin, psenPin}, 3'b110);
    intPulse = 1'b1; step(); intPulse = 1'b0;
    chk("R9 int ignored", regRdData, 8'h02);
    regWrite(8'h00);
    chk("R9 write ignored", regRdData, 8'h02);
  endtask

  task automatic t_stopExit();
    extRst = 1'b1; step(3);
    chk("R10 stop cleared", regRdData, 8'h00);
    extRst = 1'b0;
    measureRelease("R10 release edge", STAB);
    chk("R10 wdt runs", wdtRunEn, 1);
  endtask

  initial begin
    t_por();
    t_pfie();
    t_runPins();
    t_stopLocked();
    t_idle();
    t_extRun();
    t_stopEnter();
    t_stopExit();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule